// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block decides which interrupt request an 8-bit processor core takes next. Five sources feed it. The top source is a non-maskable line. Below it are three restart lines, each with its own mask bit, and the general request sits at the bottom. The highest restart line goes through a rising-edge latch. The two lower restart lines and the general request are read as levels. The non-maskable line must rise and then stay high until it is served.

The core pulses a boundary strobe between instructions. When that strobe is high and some source is eligible, the arbiter accepts the highest-priority one and drops the global interrupt enable. One cycle later it issues one of two results. A vectored source gets a fixed 16-bit service address with a one-cycle take pulse. The general request gets a one-cycle acknowledge pulse instead. The core sets and clears the enable with single-cycle strobes. It also writes the three mask bits, and the same write can discard a latched edge. A status port shows the mask, the enable and the raw restart pending bits at all times.

Top module: `irq_arbiter`

## Requirements
- R1: While and after reset, `take_o` and `ack_o` are 0, `vec_o` is 0x0000, the enable is 0, all three mask bits are 1 (masked) and the edge latch is empty. The status port therefore reads 7'b000_0_111.
- R2: When several sources are eligible at a boundary, the winner is chosen in this order: non-maskable line, then `rs_i[2]`, then `rs_i[1]`, then `rs_i[0]`, then `irq_i`.
- R3: The service addresses are 0x0024 for the non-maskable line, 0x003C for `rs_i[2]`, 0x0034 for `rs_i[1]` and 0x002C for `rs_i[0]`. Each appears on `vec_o` together with a one-cycle `take_o` pulse.
- R4: Acceptance happens only on a clock edge where `boundary_i` is 1. The take or acknowledge pulse appears in the cycle after that edge, and no pulse appears without a boundary.
- R5: The non-maskable line is served whatever the enable and mask state. It qualifies only after a rising edge, and only while its level stays high up to the boundary. A pulse that ends before the boundary is never served.
- R6: A mask bit of 1 blocks its restart line; `mask_d_i[k]` controls `rs_i[k]`. A mask write takes effect on the edge where `mask_wr_i` is 1. A blocked request changes neither the outputs nor the enable.
- R7: Any acceptance clears the enable on the same edge, and this overrides an `ie_set_i` on that edge. Otherwise `ie_set_i` sets the enable, and `ie_clr_i` clears it when `ie_set_i` is 0. Maskable sources, including `irq_i`, need the enable.
- R8: A rising edge on `rs_i[2]` is latched whatever the mask and enable state. The latch stays set until that source is accepted, or until a mask write with `edge_clr_i` = 1 clears it. A new rising edge on the same clock edge wins over the clear.
- R9: `rs_i[1]`, `rs_i[0]` and `irq_i` are level-sensitive. A request that drops before the boundary edge is not served.
- R10: The general request is answered with a one-cycle `ack_o` pulse, never together with `take_o`, and `vec_o` keeps its previous value.
- R11: `stat_o[2:0]` is the mask {rs2,rs1,rs0}. `stat_o[3]` is the enable. `stat_o[6:4]` is the raw pending state {edge latch, `rs_i[1]` level, `rs_i[0]` level}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request, edge then level |
| rs_i | input | 3 | Restart requests; bit 2 edge-latched, bits 1..0 level |
| irq_i | input | 1 | General level request, lowest priority |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ie_set_i | input | 1 | Set the global enable |
| ie_clr_i | input | 1 | Clear the global enable |
| mask_wr_i | input | 1 | Write the mask register |
| mask_d_i | input | 3 | Mask data, 1 = blocked |
| edge_clr_i | input | 1 | With a mask write, discard the edge latch |
| take_o | output | 1 | One-cycle pulse: vectored source accepted |
| vec_o | output | 16 | Service address of the last vectored acceptance |
| ack_o | output | 1 | One-cycle acknowledge for the general request |
| stat_o | output | 7 | Read-back of mask, enable and pending bits |

## Verification
Suppose the edge latch or the non-maskable qualifier holds a wrong value. That shows up at the next boundary as a missing, extra or misdirected take pulse. A wrong latch value also shows on `stat_o[6]` in the cycle after the faulty edge. A wrong enable or mask bit is visible on `stat_o` within one cycle. A cycle-accurate behavioural model runs beside the design and compares every output on every cycle. Any divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_VECTOR = 2'd1,
    EV_ACK    = 2'd2
  } irq_evt_e;

  // Slot 0 is the non-maskable source; slot k+1 is restart line k.
  function automatic int unsigned slot_addr(input int unsigned base,
                                            input int unsigned step,
                                            input int unsigned slot);
    return base + step * slot;
  endfunction

endpackage

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_RS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic [N_RS-1:0] rs_i,
  input  logic            edge_clr_i,
  input  logic            svc_nmi_i,
  input  logic            svc_top_i,
  output logic            nmi_live_o,
  output logic [N_RS-1:0] rs_pend_o
);

  localparam int unsigned TOP = N_RS - 1;

  logic nmi_q, nmi_q_nx;
  logic nmi_hold, nmi_hold_nx;

  always_comb begin
    nmi_q_nx = nmi_i;
    if (svc_nmi_i)
      nmi_hold_nx = 1'b0;
    else if (nmi_i && !nmi_q)
      nmi_hold_nx = 1'b1;
    else if (!nmi_i)
      nmi_hold_nx = 1'b0;
    else
      nmi_hold_nx = nmi_hold;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_hold <= 1'b0;
    end else begin
      nmi_q    <= nmi_q_nx;
      nmi_hold <= nmi_hold_nx;
    end
  end

  assign nmi_live_o = nmi_hold & nmi_i;

  for (genvar k = 0; k < N_RS; k++) begin : g_line
    if (k == TOP) begin : g_edge
      logic top_q, top_q_nx;
      logic top_pend, top_pend_nx;

      always_comb begin
        top_q_nx = rs_i[k];
        if (rs_i[k] && !top_q)
          top_pend_nx = 1'b1;
        else if (svc_top_i || edge_clr_i)
          top_pend_nx = 1'b0;
        else
          top_pend_nx = top_pend;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          top_q    <= 1'b0;
          top_pend <= 1'b0;
        end else begin
          top_q    <= top_q_nx;
          top_pend <= top_pend_nx;
        end
      end

      assign rs_pend_o[k] = top_pend;
    end else begin : g_level
      assign rs_pend_o[k] = rs_i[k];
    end
  end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_o = found;
  end

endmodule

// File: rtl/irq_issue.sv
module irq_issue
  import irq_pkg::*;
#(
  parameter int unsigned N_RS     = 3,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 'h24,
  parameter int unsigned VEC_STEP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [N_RS+1:0]   grant_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              mask_wr_i,
  input  logic [N_RS-1:0]   mask_d_i,
  output logic              ie_o,
  output logic [N_RS-1:0]   mask_o,
  output logic              take_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] vec_o
);

  irq_evt_e          evt;
  logic              ie_nx;
  logic              take_nx, ack_nx;
  logic [ADDR_W-1:0] vec_nx;
  int unsigned       slot;

  always_comb begin
    if (!accept_i)
      evt = EV_NONE;
    else if (grant_i[0])
      evt = EV_ACK;
    else
      evt = EV_VECTOR;
  end

  always_comb begin
    slot = 0;
    for (int unsigned i = 1; i <= N_RS; i++) begin
      if (grant_i[i]) slot = i;
    end
  end

  always_comb begin
    take_nx = (evt == EV_VECTOR);
    ack_nx  = (evt == EV_ACK);
    vec_nx  = ADDR_W'(slot_addr(VEC_BASE, VEC_STEP, slot));
    if (accept_i)
      ie_nx = 1'b0;
    else if (ie_set_i)
      ie_nx = 1'b1;
    else if (ie_clr_i)
      ie_nx = 1'b0;
    else
      ie_nx = ie_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_o   <= 1'b0;
      take_o <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      ie_o   <= ie_nx;
      take_o <= take_nx;
      ack_o  <= ack_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_o <= '1;
    else if (mask_wr_i)
      mask_o <= mask_d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      vec_o <= '0;
    else if (take_nx)
      vec_o <= vec_nx;
  end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int unsigned N_RS     = 3,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 'h24,
  parameter int unsigned VEC_STEP = 8,
  localparam int unsigned STAT_W  = 2 * N_RS + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_i,
  input  logic [N_RS-1:0]   rs_i,
  input  logic              irq_i,
  input  logic              boundary_i,
  input  logic              ie_set_i,
  input  logic              ie_clr_i,
  input  logic              mask_wr_i,
  input  logic [N_RS-1:0]   mask_d_i,
  input  logic              edge_clr_i,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o,
  output logic              ack_o,
  output logic [STAT_W-1:0] stat_o
);

  localparam int unsigned N_SRC   = N_RS + 2;
  localparam int unsigned NMI_IDX = N_SRC - 1;
  localparam int unsigned TOP_IDX = N_RS;

  logic              nmi_live;
  logic [N_RS-1:0]   rs_pend;
  logic [N_RS-1:0]   mask;
  logic              ie;
  logic [N_SRC-1:0]  cand;
  logic [N_SRC-1:0]  grant;
  logic              any;
  logic              accept;

  assign cand[0]       = irq_i & ie;
  assign cand[NMI_IDX] = nmi_live;
  for (genvar k = 0; k < N_RS; k++) begin : g_cand
    assign cand[k+1] = rs_pend[k] & ~mask[k] & ie;
  end

  assign accept = boundary_i & any;

  irq_capture #(.N_RS(N_RS)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .nmi_i      (nmi_i),
    .rs_i       (rs_i),
    .edge_clr_i (edge_clr_i & mask_wr_i),
    .svc_nmi_i  (accept & grant[NMI_IDX]),
    .svc_top_i  (accept & grant[TOP_IDX]),
    .nmi_live_o (nmi_live),
    .rs_pend_o  (rs_pend)
  );

  irq_select #(.N(N_SRC)) u_sel (
    .req_i   (cand),
    .grant_o (grant),
    .any_o   (any)
  );

  irq_issue #(
    .N_RS     (N_RS),
    .ADDR_W   (ADDR_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_iss (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .grant_i   (grant),
    .ie_set_i  (ie_set_i),
    .ie_clr_i  (ie_clr_i),
    .mask_wr_i (mask_wr_i),
    .mask_d_i  (mask_d_i),
    .ie_o      (ie),
    .mask_o    (mask),
    .take_o    (take_o),
    .ack_o     (ack_o),
    .vec_o     (vec_o)
  );

  assign stat_o = {rs_pend, ie, mask};

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned VEC_BASE = 'h24,
  parameter int unsigned VEC_STEP = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              boundary_i,
  input logic              take_o,
  input logic              ack_o,
  input logic [ADDR_W-1:0] vec_o,
  input logic              ie_w,
  input logic              mask_lo
);

  AST_TAKE_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(take_o && ack_o)); // R10

  AST_EVENT_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o || ack_o) |-> $past(boundary_i)); // R4

  AST_ACCEPT_DROPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o || ack_o) |-> !ie_w); // R7

  AST_ACK_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> $past(ie_w)); // R10

  AST_LOW_MASK_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && vec_o == ADDR_W'(VEC_BASE + VEC_STEP)) |-> !$past(mask_lo)); // R6

  AST_DISABLED_ONLY_NMI: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !$past(ie_w)) |-> (vec_o == ADDR_W'(VEC_BASE))); // R5

  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> $stable(vec_o)); // R3

endmodule

bind irq_arbiter irq_arbiter_chk #(
  .ADDR_W   (ADDR_W),
  .VEC_BASE (VEC_BASE),
  .VEC_STEP (VEC_STEP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary_i (boundary_i),
  .take_o     (take_o),
  .ack_o      (ack_o),
  .vec_o      (vec_o),
  .ie_w       (stat_o[N_RS]),
  .mask_lo    (stat_o[0])
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_i, irq_i, boundary_i, ie_set_i, ie_clr_i, mask_wr_i, edge_clr_i;
  logic [2:0]  rs_i, mask_d_i;
  logic        take_o, ack_o;
  logic [15:0] vec_o;
  logic [6:0]  stat_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .rs_i(rs_i), .irq_i(irq_i),
    .boundary_i(boundary_i), .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i),
    .mask_wr_i(mask_wr_i), .mask_d_i(mask_d_i), .edge_clr_i(edge_clr_i),
    .take_o(take_o), .vec_o(vec_o), .ack_o(ack_o), .stat_o(stat_o)
  );

  // Behavioural reference model
  bit         m_ie, m_take, m_ack, m_latch, m_prev2, m_nprev, m_narmed;
  bit  [2:0]  m_mask;
  bit  [15:0] m_vec;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ie = 0; m_take = 0; m_ack = 0; m_latch = 0; m_prev2 = 0;
      m_nprev = 0; m_narmed = 0; m_mask = 3'b111; m_vec = 16'h0000;
    end else begin
      int who; // 0 none, 1 nmi, 2 rs2, 3 rs1, 4 rs0, 5 general
      who = 0;
      if (boundary_i) begin
        if (m_narmed && nmi_i) who = 1;
        else if (m_ie && m_latch && !m_mask[2]) who = 2;
        else if (m_ie && rs_i[1] && !m_mask[1]) who = 3;
        else if (m_ie && rs_i[0] && !m_mask[0]) who = 4;
        else if (m_ie && irq_i) who = 5;
      end
      m_take = (who >= 1 && who <= 4);
      m_ack  = (who == 5);
      case (who)
        1: m_vec = 16'h0024;
        2: m_vec = 16'h003C;
        3: m_vec = 16'h0034;
        4: m_vec = 16'h002C;
        default: ;
      endcase
      if (who != 0) m_ie = 0;
      else if (ie_set_i) m_ie = 1;
      else if (ie_clr_i) m_ie = 0;
      if (rs_i[2] && !m_prev2) m_latch = 1;
      else if (who == 2 || (mask_wr_i && edge_clr_i)) m_latch = 0;
      if (who == 1) m_narmed = 0;
      else if (nmi_i && !m_nprev) m_narmed = 1;
      else if (!nmi_i) m_narmed = 0;
      if (mask_wr_i) m_mask = mask_d_i;
      m_prev2 = rs_i[2];
      m_nprev = nmi_i;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (take_o !== m_take) begin
        n_bad++; $display("FAIL R2 take act=%0b exp=%0b t=%0t", take_o, m_take, $time);
      end
      if (vec_o !== m_vec) begin
        n_bad++; $display("FAIL R3 vec act=%h exp=%h t=%0t", vec_o, m_vec, $time);
      end
      if (ack_o !== m_ack) begin
        n_bad++; $display("FAIL R10 ack act=%0b exp=%0b t=%0t", ack_o, m_ack, $time);
      end
      if (stat_o !== {m_latch, rs_i[1], rs_i[0], m_ie, m_mask}) begin
        n_bad++;
        $display("FAIL R11 stat act=%b exp=%b t=%0t", stat_o,
                 {m_latch, rs_i[1], rs_i[0], m_ie, m_mask}, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  task automatic strobe();
    boundary_i = 1; cyc(); boundary_i = 0;
  endtask

  task automatic enable_ie();
    ie_set_i = 1; cyc(); ie_set_i = 0;
  endtask

  task automatic write_mask(input logic [2:0] m, input bit clr);
    mask_wr_i = 1; mask_d_i = m; edge_clr_i = clr; cyc();
    mask_wr_i = 0; edge_clr_i = 0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; nmi_i = 0; irq_i = 0; boundary_i = 0; ie_set_i = 0; ie_clr_i = 0;
    mask_wr_i = 0; edge_clr_i = 0; rs_i = 0; mask_d_i = 0;
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    // R1 reset state
    chk(take_o == 0 && ack_o == 0, "R1 pulses", {take_o, ack_o}, 0);
    chk(stat_o == 7'b000_0_111, "R1 status", stat_o, 7'b0000111);
    chk(vec_o == 16'h0000, "R1 vector", vec_o, 0);

    write_mask(3'b000, 0);
    enable_ie();
    rs_i[0] = 1; strobe();
    chk(take_o && vec_o == 16'h002C, "R3 low restart", vec_o, 16'h002C);
    chk(stat_o[3] == 0, "R7 ie cleared", stat_o[3], 0);

    // R2 priority among mid, low and general
    enable_ie();
    rs_i = 3'b011; irq_i = 1; strobe();
    chk(take_o && vec_o == 16'h0034, "R2 mid beats low", vec_o, 16'h0034);
    rs_i = 0;

    // R10 general acknowledge
    enable_ie();
    strobe();
    chk(ack_o && !take_o, "R10 ack", {ack_o, take_o}, 2'b10);
    chk(vec_o == 16'h0034, "R10 vector kept", vec_o, 16'h0034);
    irq_i = 0;

    // R4 no boundary, no acceptance
    enable_ie();
    rs_i[1] = 1;
    for (int i = 0; i < 4; i++) begin
      cyc();
      chk(!take_o && !ack_o, "R4 idle", take_o, 0);
    end
    strobe();
    chk(take_o && vec_o == 16'h0034, "R4 after boundary", vec_o, 16'h0034);
    rs_i = 0;

    // R6 masked line ignored
    write_mask(3'b010, 0);
    enable_ie();
    rs_i[1] = 1; strobe();
    chk(!take_o, "R6 masked", take_o, 0);
    chk(stat_o[3] == 1, "R6 ie kept", stat_o[3], 1);
    cyc();
    chk(!take_o, "R6 masked later", take_o, 0);
    rs_i[1] = 0;
    write_mask(3'b000, 0);

    // R8 edge latch
    ie_clr_i = 1; cyc(); ie_clr_i = 0;
    rs_i[2] = 1; cyc(); rs_i[2] = 0; cyc();
    chk(stat_o[6] == 1, "R8 latched", stat_o[6], 1);
    enable_ie(); strobe();
    chk(take_o && vec_o == 16'h003C, "R8 served", vec_o, 16'h003C);
    chk(stat_o[6] == 0, "R8 released", stat_o[6], 0);
    rs_i[2] = 1; cyc(); rs_i[2] = 0; cyc();
    write_mask(3'b000, 1);
    chk(stat_o[6] == 0, "R8 cleared by write", stat_o[6], 0);

    // R5 non-maskable
    write_mask(3'b111, 0);
    nmi_i = 1; cyc(); strobe();
    chk(take_o && vec_o == 16'h0024, "R5 nmi", vec_o, 16'h0024);
    nmi_i = 0; cyc();
    nmi_i = 1; cyc(); nmi_i = 0; cyc(); strobe();
    chk(!take_o, "R5 short pulse", take_o, 0);

    // R9 level dropped before boundary
    write_mask(3'b000, 0);
    enable_ie();
    rs_i[0] = 1; cyc(); rs_i[0] = 0; strobe();
    chk(!take_o, "R9 level gone", take_o, 0);
    chk(stat_o[3] == 1, "R9 ie kept", stat_o[3], 1);

    // R7 accept overrides set
    rs_i[0] = 1; ie_set_i = 1; strobe(); ie_set_i = 0;
    chk(take_o && stat_o[3] == 0, "R7 accept wins", stat_o[3], 0);
    rs_i[0] = 0;

    // R11 status layout
    write_mask(3'b101, 0);
    enable_ie();
    rs_i[1] = 1; #1;
    chk(stat_o == 7'b010_1_101, "R11 layout", stat_o, 7'b0101101);
    rs_i = 0;

    // Mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      boundary_i = ($urandom % 3) == 0;
      ie_set_i   = ($urandom % 6) == 0;
      ie_clr_i   = ($urandom % 14) == 0;
      mask_wr_i  = ($urandom % 16) == 0;
      mask_d_i   = 3'($urandom);
      edge_clr_i = ($urandom % 2) == 0;
      irq_i      = ($urandom % 4) == 0;
      rs_i       = 3'($urandom % 8) & 3'($urandom % 8);
      if (($urandom % 10) == 0) nmi_i = ~nmi_i;
      cyc();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule